// File: doc/BRIEF.md
# GPIO Input Filter and Interrupt Capture

This block receives one asynchronous level per general-purpose pin, brings each into the clock domain through a flop chain, and then passes it through a per-pin stability filter. A pin's visible level (`in_level`) takes a new value only once the synchronised sample has shown that value on consecutive clock edges for a set number of cycles. A pulse shorter than that never reaches `in_level`.

From the filtered level, four conditions are evaluated for every pin: a 0-to-1 transition, a 1-to-0 transition, the level being 1 and the level being 0. Each condition has its own enable vector. An enabled condition sets a sticky pending bit. A register bank clears a pending bit by pulsing the matching bit of a clear vector, which is a write of one to clear. Each pin drives its own interrupt line. That line is high while any of its four pending bits is set and that type is still enabled.

Each pin's filter is a two-state machine. In `FLT_STEADY` the synchronised sample matches `in_level`. The *diverge* transition leads to `FLT_QUALIFY` when the sample differs. In `FLT_QUALIFY` a run counter tracks how long the new value has lasted. There are two ways back to `FLT_STEADY`. The *commit* transition copies the sample into `in_level` once the run counter reaches the required length. The *abort* transition is taken when the sample returns to the old level, and it leaves `in_level` unchanged.

Top module: `gpio_irq_filter`

## Requirements
- R1: After reset, `in_level`, all four pending vectors and `irq` are all zero.
- R2: With the default parameters, a pad change that is first sampled at rising edge E0 and then held appears on `in_level` after edge E0+3, and not earlier. A pad pulse one cycle long never changes `in_level`. A pad pulse two cycles long does reach `in_level`.
- R3: When bit i of `in_level` goes from 0 to 1 and `rise_en[i]` is 1, `rise_pend[i]` is set at the next edge. When `rise_en[i]` is 0, the transition sets nothing.
- R4: When bit i of `in_level` goes from 1 to 0 and `fall_en[i]` is 1, `fall_pend[i]` is set at the next edge. When `fall_en[i]` is 0, the transition sets nothing.
- R5: On every edge at which `in_level[i]` is 1 and `high_en[i]` is 1, `high_pend[i]` is set.
- R6: On every edge at which `in_level[i]` is 0 and `low_en[i]` is 1, `low_pend[i]` is set.
- R7: Any subset of the four types, including all four, can be enabled on the same pin, and each type sets its own pending bit independently of the others.
- R8: A pending bit stays at 1 until its clear pulse is 1 at the same bit position. Clear bits that are 0 and clears aimed at other positions leave it unchanged.
- R9: When a set condition and a clear pulse hit the same pending bit on the same edge, the bit ends at 1.
- R10: `irq[i]` equals the OR over the four types of (pending[i] AND enable[i]). Clearing an enable removes that type's contribution to `irq` but leaves its pending bit unchanged.
- R11: Bit i of every vector port refers to pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad_in | input | 16 | Asynchronous pad levels, one bit per pin |
| rise_en | input | 16 | Rising-edge interrupt enables |
| fall_en | input | 16 | Falling-edge interrupt enables |
| high_en | input | 16 | High-level interrupt enables |
| low_en | input | 16 | Low-level interrupt enables |
| rise_clr | input | 16 | Write-one-to-clear pulses for `rise_pend` |
| fall_clr | input | 16 | Write-one-to-clear pulses for `fall_pend` |
| high_clr | input | 16 | Write-one-to-clear pulses for `high_pend` |
| low_clr | input | 16 | Write-one-to-clear pulses for `low_pend` |
| in_level | output | 16 | Filtered input level |
| rise_pend | output | 16 | Rising-edge pending bits |
| fall_pend | output | 16 | Falling-edge pending bits |
| high_pend | output | 16 | High-level pending bits |
| low_pend | output | 16 | Low-level pending bits |
| irq | output | 16 | Per-pin interrupt lines |

## Verification
The bench builds the block with its default parameters: 16 pins, a two-flop synchroniser and a two-cycle stability requirement. With these values the input path has a four-edge latency, which the bench checks at exact edges. They also put both pulse cases within reach: a pulse one cycle long, which must be rejected, and a pulse two cycles long, which must pass. Sixteen pins allow enabled and disabled pins to be mixed in one vector, so an edge on an unenabled neighbour and a clear aimed at the wrong bit position are exercised alongside the wanted events.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    // Stability filter states, one machine per pin
    typedef enum logic [0:0] {
        FLT_STEADY  = 1'b0,
        FLT_QUALIFY = 1'b1
    } flt_state_e;

    // Interrupt condition kinds; index into the packed kind arrays
    typedef enum logic [1:0] {
        EV_RISE = 2'd0,
        EV_FALL = 2'd1,
        EV_HIGH = 2'd2,
        EV_LOW  = 2'd3
    } ev_kind_e;

    localparam int EV_KINDS = 4;
endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter
    import gpio_irq_pkg::*;
#(
    parameter int STABLE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    output logic level
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] RUN_LAST = CW'(STABLE_CYCLES - 1);

    flt_state_e    state_q, state_d;
    logic [CW-1:0] run_q, run_d;
    logic          level_q, level_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FLT_STEADY;
            run_q   <= '0;
            level_q <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            level_q <= level_d;
        end
    end

    // Next state and committed level
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        level_d = level_q;
        unique case (state_q)
            FLT_STEADY: begin
                if (sample != level_q) begin
                    if (STABLE_CYCLES <= 1) begin
                        level_d = sample;          // commit at once
                    end else begin
                        state_d = FLT_QUALIFY;     // diverge
                        run_d   = CW'(1);
                    end
                end
            end
            FLT_QUALIFY: begin
                if (sample == level_q) begin
                    state_d = FLT_STEADY;          // abort
                    run_d   = '0;
                end else if (run_q >= RUN_LAST) begin
                    state_d = FLT_STEADY;          // commit
                    run_d   = '0;
                    level_d = sample;
                end else begin
                    run_d = run_q + 1'b1;
                end
            end
            default: begin
                state_d = FLT_STEADY;
                run_d   = '0;
            end
        endcase
    end

    assign level = level_q;

    generate
        if (STABLE_CYCLES >= 2) begin : g_chk
            // R2: a committed level was seen on the two preceding edges
            a_r2_stable_before_commit: assert property (@(posedge clk) disable iff (!rst_n)
                (level_q != $past(level_q)) |->
                    ($past(sample) == level_q && $past(sample, 2) == level_q));
        end
    endgenerate

    // R2: an abort never moves the committed level
    a_r2_abort_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLT_QUALIFY && sample == level_q) |=> $stable(level_q));
endmodule

// File: rtl/gpio_filter_bank.sv
module gpio_filter_bank #(
    parameter int WIDTH         = 16,
    parameter int STABLE_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sample,
    output logic [WIDTH-1:0] level
);
    generate
        for (genvar p = 0; p < WIDTH; p++) begin : g_pin
            gpio_pin_filter #(
                .STABLE_CYCLES(STABLE_CYCLES)
            ) u_flt (
                .clk   (clk),
                .rst_n (rst_n),
                .sample(sample[p]),
                .level (level[p])
            );
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_capture.sv
module gpio_irq_capture
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [WIDTH-1:0]              level,
    input  logic [EV_KINDS-1:0][WIDTH-1:0] en,
    input  logic [EV_KINDS-1:0][WIDTH-1:0] clr,
    output logic [EV_KINDS-1:0][WIDTH-1:0] pend,
    output logic [WIDTH-1:0]              irq
);
    logic [WIDTH-1:0]               level_prev_q;
    logic [EV_KINDS-1:0][WIDTH-1:0] cond;
    logic [EV_KINDS-1:0][WIDTH-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) level_prev_q <= '0;
        else        level_prev_q <= level;
    end

    always_comb begin
        cond[EV_RISE] = level & ~level_prev_q;
        cond[EV_FALL] = ~level & level_prev_q;
        cond[EV_HIGH] = level;
        cond[EV_LOW]  = ~level;
    end

    generate
        for (genvar k = 0; k < EV_KINDS; k++) begin : g_kind
            // set wins over a simultaneous clear
            always_ff @(posedge clk) begin
                if (!rst_n) pend_q[k] <= '0;
                else        pend_q[k] <= (pend_q[k] & ~clr[k]) | (cond[k] & en[k]);
            end

            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                // R3, R4, R5, R6, R9: enabled condition leaves the bit set
                a_r9_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
                    (cond[k][i] && en[k][i]) |=> pend_q[k][i]);
                // R8: sticky without a clear pulse
                a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                    (pend_q[k][i] && !clr[k][i]) |=> pend_q[k][i]);
                // R8: clear takes effect when no set competes
                a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
                    (pend_q[k][i] && clr[k][i] && !(cond[k][i] && en[k][i])) |=> !pend_q[k][i]);
                // R7: no bit rises without its own enabled condition
                a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
                    (!pend_q[k][i] && !(cond[k][i] && en[k][i])) |=> !pend_q[k][i]);
            end
        end
    endgenerate

    always_comb begin
        irq = '0;
        for (int k = 0; k < EV_KINDS; k++) irq = irq | (pend_q[k] & en[k]);
    end

    assign pend = pend_q;
endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter
    import gpio_irq_pkg::*;
#(
    parameter int PIN_COUNT     = 16,
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_COUNT-1:0] pad_in,
    input  logic [PIN_COUNT-1:0] rise_en,
    input  logic [PIN_COUNT-1:0] fall_en,
    input  logic [PIN_COUNT-1:0] high_en,
    input  logic [PIN_COUNT-1:0] low_en,
    input  logic [PIN_COUNT-1:0] rise_clr,
    input  logic [PIN_COUNT-1:0] fall_clr,
    input  logic [PIN_COUNT-1:0] high_clr,
    input  logic [PIN_COUNT-1:0] low_clr,
    output logic [PIN_COUNT-1:0] in_level,
    output logic [PIN_COUNT-1:0] rise_pend,
    output logic [PIN_COUNT-1:0] fall_pend,
    output logic [PIN_COUNT-1:0] high_pend,
    output logic [PIN_COUNT-1:0] low_pend,
    output logic [PIN_COUNT-1:0] irq
);
    logic [PIN_COUNT-1:0]               synced;
    logic [EV_KINDS-1:0][PIN_COUNT-1:0] en_vec;
    logic [EV_KINDS-1:0][PIN_COUNT-1:0] clr_vec;
    logic [EV_KINDS-1:0][PIN_COUNT-1:0] pend_vec;

    always_comb begin
        en_vec[EV_RISE]  = rise_en;
        en_vec[EV_FALL]  = fall_en;
        en_vec[EV_HIGH]  = high_en;
        en_vec[EV_LOW]   = low_en;
        clr_vec[EV_RISE] = rise_clr;
        clr_vec[EV_FALL] = fall_clr;
        clr_vec[EV_HIGH] = high_clr;
        clr_vec[EV_LOW]  = low_clr;
    end

    gpio_sync_chain #(
        .WIDTH (PIN_COUNT),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pad_in),
        .sync_out(synced)
    );

    gpio_filter_bank #(
        .WIDTH        (PIN_COUNT),
        .STABLE_CYCLES(STABLE_CYCLES)
    ) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .sample(synced),
        .level (in_level)
    );

    gpio_irq_capture #(
        .WIDTH(PIN_COUNT)
    ) u_capture (
        .clk  (clk),
        .rst_n(rst_n),
        .level(in_level),
        .en   (en_vec),
        .clr  (clr_vec),
        .pend (pend_vec),
        .irq  (irq)
    );

    assign rise_pend = pend_vec[EV_RISE];
    assign fall_pend = pend_vec[EV_FALL];
    assign high_pend = pend_vec[EV_HIGH];
    assign low_pend  = pend_vec[EV_LOW];

    // R10: a raised line always has an enabled pending source behind it
    a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |-> ((irq & ~((rise_pend & rise_en) | (fall_pend & fall_en) |
                                  (high_pend & high_en) | (low_pend & low_en))) == '0));
endmodule

// File: tb/gpio_irq_filter_test.sv
module gpio_irq_filter_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] rise_en = '0, fall_en = '0, high_en = '0, low_en = '0;
    logic [W-1:0] rise_clr = '0, fall_clr = '0, high_clr = '0, low_clr = '0;
    logic [W-1:0] in_level, rise_pend, fall_pend, high_pend, low_pend, irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_irq_filter uut (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
        .rise_en(rise_en), .fall_en(fall_en), .high_en(high_en), .low_en(low_en),
        .rise_clr(rise_clr), .fall_clr(fall_clr), .high_clr(high_clr), .low_clr(low_clr),
        .in_level(in_level), .rise_pend(rise_pend), .fall_pend(fall_pend),
        .high_pend(high_pend), .low_pend(low_pend), .irq(irq)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        rise_clr = '1; fall_clr = '1; high_clr = '1; low_clr = '1;
        step(1);
        rise_clr = '0; fall_clr = '0; high_clr = '0; low_clr = '0;
    endtask

    task automatic settle();
        pad_in = '0; rise_en = '0; fall_en = '0; high_en = '0; low_en = '0;
        step(6);
        clear_all();
    endtask

    task automatic t_reset();
        step(2);
        rst_n = 1'b1;
        step(3);
        check("R1 in_level", in_level, '0);
        check("R1 rise_pend", rise_pend, '0);
        check("R1 fall_pend", fall_pend, '0);
        check("R1 high_pend", high_pend, '0);
        check("R1 low_pend", low_pend, '0);
        check("R1 irq", irq, '0);
    endtask

    task automatic t_latency();
        pad_in = 16'h0008;
        step(3);
        check("R2 not yet visible", in_level, 16'h0000);
        step(1);
        check("R2 visible after E0+3", in_level, 16'h0008);
        pad_in = '0;
        step(4);
        check("R2 back low", in_level, 16'h0000);
        settle();
    endtask

    task automatic t_glitch();
        rise_en = '1;
        pad_in = 16'h0020;
        step(1);
        pad_in = '0;
        step(2);
        check("R2 glitch level", in_level, 16'h0000);
        step(6);
        check("R2 glitch level late", in_level, 16'h0000);
        check("R2 glitch no rise", rise_pend, 16'h0000);
        settle();
    endtask

    task automatic t_two_cycle();
        rise_en = '1;
        pad_in = 16'h0040;
        step(2);
        pad_in = '0;
        step(2);
        check("R2 two-cycle pulse passes", in_level, 16'h0040);
        step(1);
        check("R3 rise from pulse", rise_pend, 16'h0040);
        step(4);
        check("R4 fall disabled sets nothing", fall_pend, 16'h0000);
        settle();
    endtask

    task automatic t_edges_and_levels();
        // R3 / R11: pins 0 and 4 enabled, pin 1 rises without enable
        rise_en = 16'h0011;
        pad_in  = 16'h0013;
        step(4);
        check("R3 rise before latency", rise_pend, 16'h0000);
        step(1);
        check("R3 rise enabled pins only", rise_pend, 16'h0011);
        check("R10 irq from rise", irq, 16'h0011);
        // R4: pins 0 and 1 fall, only pin 1 enabled
        fall_en = 16'h0002;
        pad_in  = 16'h0010;
        step(5);
        check("R4 fall enabled pin only", fall_pend, 16'h0002);
        check("R8 rise still pending", rise_pend, 16'h0011);
        // R8: zero clear bits do nothing, a one clears that position only
        rise_clr = 16'hFFEE;
        step(1);
        rise_clr = '0;
        check("R8 clear wrong bits no effect", rise_pend, 16'h0011);
        rise_clr = 16'h0001;
        step(1);
        rise_clr = '0;
        check("R8 clear one position", rise_pend, 16'h0010);
        // R5 and R9: pin 4 is high
        high_en = 16'h0010;
        step(1);
        check("R5 high level sets", high_pend, 16'h0010);
        high_clr = 16'h0010;
        step(1);
        high_clr = '0;
        check("R9 set wins over clear", high_pend, 16'h0010);
        high_en  = '0;
        high_clr = 16'h0010;
        step(1);
        high_clr = '0;
        check("R8 clear when condition masked", high_pend, 16'h0000);
        // R6 and R10: pin 15 is low
        low_en = 16'h8000;
        step(1);
        check("R6 low level sets", low_pend, 16'h8000);
        check("R10 irq includes low", irq & 16'h8000, 16'h8000);
        low_en = '0;
        step(1);
        check("R10 pending kept when masked", low_pend, 16'h8000);
        check("R10 irq masked", irq & 16'h8000, 16'h0000);
        settle();
    endtask

    task automatic t_combo();
        rise_en = 16'h0200; fall_en = 16'h0200; high_en = 16'h0200; low_en = 16'h0200;
        step(1);
        check("R7 low first", low_pend, 16'h0200);
        pad_in = 16'h0200;
        step(5);
        check("R7 rise", rise_pend, 16'h0200);
        check("R7 high", high_pend, 16'h0200);
        pad_in = '0;
        step(5);
        check("R7 fall", fall_pend, 16'h0200);
        check("R10 irq on combo pin", irq, 16'h0200);
        clear_all();
        check("R7 rise cleared", rise_pend, 16'h0000);
        check("R7 fall cleared", fall_pend, 16'h0000);
        check("R7 high cleared", high_pend, 16'h0000);
        check("R9 low reasserts", low_pend, 16'h0200);
        settle();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        t_reset();
        t_latency();
        t_glitch();
        t_two_cycle();
        t_edges_and_levels();
        t_combo();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule